// File: doc/BRIEF.md
# Packet-Key Indexed Branch Predictor

This block predicts the direction of conditional branches for a small packet-processing core. Packets of one flow tend to take the same path through the program. The predictor therefore keys its state on a search key that the core forms from header fields. When a packet starts, the key is compared in parallel against a small fully associative key store. On a hit, the predictions for that packet are replayed from the taken/not-taken string recorded for the key, one bit per dynamic branch. A replay step is a pointer step, with no table lookup.

On a miss, the block claims an entry in round-robin order. A small gshare table supplies the predictions for the packet, and the real outcomes are appended to the new entry. Every resolved branch also trains the gshare counters and its global history, whatever the source of the prediction. A replayed bit that turns out wrong is overwritten, so an entry follows changes in its flow. When a replayed packet runs past the recorded length of its entry, the rest of the packet falls back to gshare.

The core raises `pkt_start` with the key, then for each branch raises `pred_req` with the PC. It reports the outcome on the resolve port, in program order, in the same cycle as the prediction or later.

Top module: `pkbp_top`

## Requirements
- R1: After reset every key entry is invalid, every gshare counter holds 2'b01 (weakly not-taken), the global history is zero and `pkt_hit` is 0. The first packet after reset misses, and a prediction made before any training is not-taken.
- R2: On `pkt_start`, the key is compared against all valid stored keys. From the next cycle until the next `pkt_start`, `pkt_hit` is 1 exactly when a match was found.
- R3: In a hit packet, the k-th prediction (k counted from 0, one per `pred_req`) returns bit k of the entry's history with `pred_from_hist`=1 while k is below the recorded length. This already holds in the cycle right after `pkt_start`.
- R4: In a hit packet, once k reaches the recorded length, predictions come from gshare and `pred_from_hist` is 0.
- R5: A miss claims entry `rr` and stores the key there with recorded length 0. `rr` starts at 0 and advances by one per miss, wrapping after the last entry, so the oldest allocation is evicted first.
- R6: In a miss packet, each resolved outcome is written at position equal to the recorded length, and the length then grows by one. This stops at HIST_M (128 by default), and later outcomes of that packet are not stored.
- R7: In a hit packet, the resolve of the k-th branch with k below the recorded length writes the actual outcome into bit k. A mispredicted bit is therefore replayed with the new value in later packets with the same key.
- R8: gshare prediction is bit 1 of the 2-bit counter at index GHR XOR PC[8:2]. Every resolve updates the counter at GHR XOR res_pc[8:2] with saturation at 0 and 3, then shifts the outcome into GHR bit 0.
- R9: A prediction requested in the `pkt_start` cycle comes from gshare. A resolve in that cycle trains gshare only and does not touch any history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | First cycle of a new packet |
| pkt_key | input | KEY_W | Search key of the new packet |
| pred_req | input | 1 | Prediction wanted for a branch this cycle |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, valid in the `pred_req` cycle |
| pred_from_hist | output | 1 | Prediction came from the replayed history |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch |
| pkt_hit | output | 1 | Current packet's key matched a stored entry |

## Verification
`pred_taken` and `pred_from_hist` are combinational from registered state, so they are due in the same cycle as `pred_req`. The bench samples them 5 ns after the falling edge at which it drove the request. `pkt_hit` changes on the rising edge that captures `pkt_start` and is sampled 1 ns after that edge. A history or counter written by a resolve affects predictions from the next cycle on. The bench's reference model therefore applies each cycle's prediction against the pre-edge state and only then applies the resolve, matching that order.

// File: rtl/pkbp_pkg.sv
package pkbp_pkg;

   localparam logic [1:0] CTR_WEAK_NT = 2'b01;

   function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
      logic [1:0] n;
      n = c;
      if (up && c != 2'b11)
         n = c + 2'b01;
      else if (!up && c != 2'b00)
         n = c - 2'b01;
      return n;
   endfunction

endpackage

// File: rtl/pkbp_key_cam.sv
module pkbp_key_cam #(
   parameter int KEY_W = 32,
   parameter int N_ENT = 16,
   localparam int EI_W = $clog2(N_ENT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] lk_key,
   input  logic             alloc,
   output logic             hit,
   output logic [EI_W-1:0]  hit_idx,
   output logic [EI_W-1:0]  alloc_idx
);

   if (N_ENT < 2) begin : g_bad_ent
      $error("pkbp_key_cam: N_ENT must be at least 2");
   end

   logic [N_ENT-1:0] valid_q;
   logic [N_ENT-1:0] match;
   logic [KEY_W-1:0] tag_q [N_ENT];
   logic [EI_W-1:0]  rr_q;

   for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
      assign match[e] = valid_q[e] && (tag_q[e] == lk_key);
   end

   always_comb begin
      hit     = |match;
      hit_idx = '0;
      for (int e = N_ENT - 1; e >= 0; e--)
         if (match[e]) hit_idx = EI_W'(e);
   end

   assign alloc_idx = rr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         rr_q    <= '0;
      end else if (alloc) begin
         valid_q[rr_q] <= 1'b1;
         rr_q <= (rr_q == EI_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc) tag_q[rr_q] <= lk_key;
   end

   AST_CAM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R5
   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      alloc && rr_q != EI_W'(N_ENT - 1) |=> rr_q == $past(rr_q) + 1'b1); // R5
   AST_RR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      alloc && rr_q == EI_W'(N_ENT - 1) |=> rr_q == '0); // R5
   AST_ALLOC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> valid_q[$past(rr_q)]); // R5

endmodule

// File: rtl/pkbp_hist_store.sv
module pkbp_hist_store #(
   parameter int N_ENT  = 16,
   parameter int HIST_M = 128,
   localparam int EI_W  = $clog2(N_ENT),
   localparam int POS_W = $clog2(HIST_M),
   localparam int LEN_W = $clog2(HIST_M + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [EI_W-1:0]  clr_idx,
   input  logic             wr_en,
   input  logic             wr_grow,
   input  logic [EI_W-1:0]  wr_idx,
   input  logic [POS_W-1:0] wr_pos,
   input  logic             wr_bit,
   input  logic [EI_W-1:0]  rd_idx,
   input  logic [POS_W-1:0] rd_pos,
   output logic             rd_bit,
   output logic [LEN_W-1:0] rd_len
);

   if (HIST_M < 2) begin : g_bad_len
      $error("pkbp_hist_store: HIST_M must be at least 2");
   end

   logic [HIST_M-1:0] hist_q [N_ENT];
   logic [LEN_W-1:0]  len_q  [N_ENT];

   assign rd_bit = hist_q[rd_idx][rd_pos];
   assign rd_len = len_q[rd_idx];

   always_ff @(posedge clk) begin
      if (wr_en) hist_q[wr_idx][wr_pos] <= wr_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < N_ENT; e++) len_q[e] <= '0;
      end else if (clr) begin
         len_q[clr_idx] <= '0;
      end else if (wr_en && wr_grow) begin
         len_q[wr_idx] <= len_q[wr_idx] + 1'b1;
      end
   end

   AST_NO_CLR_WR: assert property (@(posedge clk) disable iff (!rst_n) !(clr && wr_en)); // R9
   AST_APPEND_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_grow |-> LEN_W'(wr_pos) == len_q[wr_idx]); // R6
   AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      rd_len <= LEN_W'(HIST_M)); // R6
   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> len_q[$past(clr_idx)] == '0); // R5

endmodule

// File: rtl/pkbp_gshare.sv
module pkbp_gshare
   import pkbp_pkg::*;
#(
   parameter int GS_ENT  = 128,
   parameter int PC_W    = 32,
   parameter int PC_LSB  = 2,
   parameter bit USE_GHR = 1'b1,
   localparam int GI_W   = $clog2(GS_ENT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] prd_pc,
   output logic            prd_taken,
   input  logic            trn_en,
   input  logic [PC_W-1:0] trn_pc,
   input  logic            trn_taken
);

   if ((GS_ENT & (GS_ENT - 1)) != 0 || GS_ENT < 2) begin : g_bad_gs
      $error("pkbp_gshare: GS_ENT must be a power of two");
   end
   if (PC_LSB + GI_W > PC_W) begin : g_bad_pc
      $error("pkbp_gshare: PC too narrow for index");
   end

   logic [1:0]      ctr_q [GS_ENT];
   logic [GI_W-1:0] prd_idx;
   logic [GI_W-1:0] trn_idx;
   logic            unused_pc_bits;

   assign unused_pc_bits = ^prd_pc ^ ^trn_pc;

   if (USE_GHR) begin : g_gshare
      logic [GI_W-1:0] ghr_q;
      assign prd_idx = ghr_q ^ prd_pc[PC_LSB +: GI_W];
      assign trn_idx = ghr_q ^ trn_pc[PC_LSB +: GI_W];
      always_ff @(posedge clk) begin
         if (!rst_n)
            ghr_q <= '0;
         else if (trn_en)
            ghr_q <= {ghr_q[GI_W-2:0], trn_taken};
      end
      AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
         trn_en |=> ghr_q[0] == $past(trn_taken)); // R8
   end else begin : g_bimodal
      assign prd_idx = prd_pc[PC_LSB +: GI_W];
      assign trn_idx = trn_pc[PC_LSB +: GI_W];
   end

   assign prd_taken = ctr_q[prd_idx][1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < GS_ENT; i++) ctr_q[i] <= CTR_WEAK_NT;
      end else if (trn_en) begin
         ctr_q[trn_idx] <= ctr_step(ctr_q[trn_idx], trn_taken);
      end
   end

   AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      trn_en && trn_taken && ctr_q[trn_idx] == 2'b11 |=> ctr_q[$past(trn_idx)] == 2'b11); // R8
   AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      trn_en && !trn_taken && ctr_q[trn_idx] == 2'b00 |=> ctr_q[$past(trn_idx)] == 2'b00); // R8

endmodule

// File: rtl/pkbp_top.sv
module pkbp_top #(
   parameter int KEY_W      = 32,
   parameter int N_ENT      = 16,
   parameter int HIST_M     = 128,
   parameter int GS_ENT     = 128,
   parameter int PC_W       = 32,
   parameter int PC_LSB     = 2,
   parameter bit GS_USE_GHR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_start,
   input  logic [KEY_W-1:0] pkt_key,
   input  logic             pred_req,
   input  logic [PC_W-1:0]  pred_pc,
   output logic             pred_taken,
   output logic             pred_from_hist,
   input  logic             res_valid,
   input  logic [PC_W-1:0]  res_pc,
   input  logic             res_taken,
   output logic             pkt_hit
);

   localparam int EI_W  = $clog2(N_ENT);
   localparam int POS_W = $clog2(HIST_M);
   localparam int LEN_W = $clog2(HIST_M + 1);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(HIST_M);

   // packet context
   logic             pkt_act_q;
   logic             hit_q;
   logic [EI_W-1:0]  ent_q;
   logic [LEN_W-1:0] prd_ptr_q;
   logic [LEN_W-1:0] res_ptr_q;

   // sub-block wiring
   logic             cam_hit;
   logic [EI_W-1:0]  cam_hit_idx;
   logic [EI_W-1:0]  cam_alloc_idx;
   logic             cam_alloc;
   logic             hs_bit;
   logic [LEN_W-1:0] hs_len;
   logic             hs_wr_en;
   logic             hs_wr_grow;
   logic [POS_W-1:0] hs_wr_pos;
   logic             gs_taken;
   logic             use_hist;
   logic             res_in_pkt;

   assign cam_alloc  = pkt_start && !cam_hit;
   assign res_in_pkt = res_valid && pkt_act_q && !pkt_start;

   pkbp_key_cam #(
      .KEY_W(KEY_W),
      .N_ENT(N_ENT)
   ) u_cam (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_key    (pkt_key),
      .alloc     (cam_alloc),
      .hit       (cam_hit),
      .hit_idx   (cam_hit_idx),
      .alloc_idx (cam_alloc_idx)
   );

   pkbp_hist_store #(
      .N_ENT (N_ENT),
      .HIST_M(HIST_M)
   ) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cam_alloc),
      .clr_idx (cam_alloc_idx),
      .wr_en   (hs_wr_en),
      .wr_grow (hs_wr_grow),
      .wr_idx  (ent_q),
      .wr_pos  (hs_wr_pos),
      .wr_bit  (res_taken),
      .rd_idx  (ent_q),
      .rd_pos  (prd_ptr_q[POS_W-1:0]),
      .rd_bit  (hs_bit),
      .rd_len  (hs_len)
   );

   pkbp_gshare #(
      .GS_ENT (GS_ENT),
      .PC_W   (PC_W),
      .PC_LSB (PC_LSB),
      .USE_GHR(GS_USE_GHR)
   ) u_gs (
      .clk       (clk),
      .rst_n     (rst_n),
      .prd_pc    (pred_pc),
      .prd_taken (gs_taken),
      .trn_en    (res_valid),
      .trn_pc    (res_pc),
      .trn_taken (res_taken)
   );

   // prediction source select
   assign use_hist       = pkt_act_q && hit_q && !pkt_start && (prd_ptr_q < hs_len);
   assign pred_from_hist = use_hist;
   assign pred_taken     = use_hist ? hs_bit : gs_taken;
   assign pkt_hit        = pkt_act_q && hit_q;

   // history write: overwrite on replay, append on record
   always_comb begin
      hs_wr_en   = 1'b0;
      hs_wr_grow = 1'b0;
      hs_wr_pos  = '0;
      if (res_in_pkt) begin
         if (hit_q) begin
            if (res_ptr_q < hs_len) begin
               hs_wr_en  = 1'b1;
               hs_wr_pos = res_ptr_q[POS_W-1:0];
            end
         end else if (hs_len < LEN_MAX) begin
            hs_wr_en   = 1'b1;
            hs_wr_grow = 1'b1;
            hs_wr_pos  = hs_len[POS_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_act_q <= 1'b0;
         hit_q     <= 1'b0;
         ent_q     <= '0;
         prd_ptr_q <= '0;
         res_ptr_q <= '0;
      end else if (pkt_start) begin
         pkt_act_q <= 1'b1;
         hit_q     <= cam_hit;
         ent_q     <= cam_hit ? cam_hit_idx : cam_alloc_idx;
         prd_ptr_q <= '0;
         res_ptr_q <= '0;
      end else begin
         if (pred_req && prd_ptr_q != LEN_MAX) prd_ptr_q <= prd_ptr_q + 1'b1;
         if (res_in_pkt && res_ptr_q != LEN_MAX) res_ptr_q <= res_ptr_q + 1'b1;
      end
   end

   AST_HIST_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      pred_from_hist |-> pkt_hit); // R3
   AST_START_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> !pred_from_hist); // R9
   AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start && !cam_hit |=> hs_len == '0 && !pkt_hit); // R5
   AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start && cam_hit |=> pkt_hit); // R2
   AST_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_hit && !pkt_start && prd_ptr_q >= hs_len |-> pred_taken == gs_taken); // R4

endmodule

// File: tb/pkbp_top_test.sv
module pkbp_top_test;

   localparam int NE = 16;
   localparam int HM = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_start = 1'b0;
   logic [31:0] pkt_key = '0;
   logic        pred_req = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken;
   logic        pred_from_hist;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic        res_taken = 1'b0;
   logic        pkt_hit;

   always #10 clk = ~clk;

   pkbp_top uut (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_key(pkt_key),
      .pred_req(pred_req), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_from_hist(pred_from_hist), .res_valid(res_valid), .res_pc(res_pc),
      .res_taken(res_taken), .pkt_hit(pkt_hit)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state
   bit          m_valid [NE];
   bit [31:0]   m_tag   [NE];
   int          m_len   [NE];
   bit [HM-1:0] m_hist  [NE];
   int          m_rr = 0;
   bit [1:0]    m_ctr   [128];
   bit [6:0]    m_ghr = '0;
   bit          m_act = 0, m_hit = 0;
   int          m_ent = 0, m_pp = 0, m_rp = 0;

   bit [1:0] q_exp [$];
   string    q_tag [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input bit st, input bit [31:0] key, input bit pr, input bit [31:0] ppc,
                        input bit rv, input bit [31:0] rpc, input bit rt, input string tag);
      bit use_h, exp_t;
      bit [6:0] ix;
      @(negedge clk);
      pkt_start = st; pkt_key = key; pred_req = pr; pred_pc = ppc;
      res_valid = rv; res_pc = rpc; res_taken = rt;
      if (pr) begin
         use_h = m_act && m_hit && !st && (m_pp < m_len[m_ent]);
         ix = m_ghr ^ ppc[8:2];
         exp_t = use_h ? m_hist[m_ent][m_pp] : m_ctr[ix][1];
         q_exp.push_back({use_h, exp_t});
         q_tag.push_back(tag != "" ? tag : (use_h ? "R3" : "R8"));
         if (!st && m_pp < HM) m_pp++;
      end
      if (rv) begin
         ix = m_ghr ^ rpc[8:2];
         if (rt && m_ctr[ix] != 2'd3) m_ctr[ix]++;
         else if (!rt && m_ctr[ix] != 2'd0) m_ctr[ix]--;
         m_ghr = {m_ghr[5:0], rt};
         if (!st && m_act) begin
            if (m_hit) begin
               if (m_rp < m_len[m_ent]) m_hist[m_ent][m_rp] = rt;
            end else if (m_len[m_ent] < HM) begin
               m_hist[m_ent][m_len[m_ent]] = rt;
               m_len[m_ent]++;
            end
            if (m_rp < HM) m_rp++;
         end
      end
      if (st) begin
         m_hit = 0;
         for (int e = 0; e < NE; e++)
            if (m_valid[e] && m_tag[e] == key) begin m_hit = 1; m_ent = e; end
         if (!m_hit) begin
            m_ent = m_rr; m_valid[m_rr] = 1; m_tag[m_rr] = key; m_len[m_rr] = 0;
            m_rr = (m_rr + 1) % NE;
         end
         m_act = 1; m_pp = 0; m_rp = 0;
      end
   endtask

   task automatic br(input bit [31:0] pc, input bit t, input string tag);
      drive(0, 0, 1, pc, 1, pc, t, tag);
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic start(input bit [31:0] key, input bit pr, input bit rv);
      drive(1, key, pr, 32'h300, rv, 32'h300, 1'b1, "R9");
      @(posedge clk); #1;
      chk(pkt_hit == m_hit, m_hit ? "R2 hit flag" : "R5 miss flag", pkt_hit, m_hit);
   endtask

   // scoreboard monitor
   initial begin
      bit [1:0] e;
      string t;
      forever begin
         @(negedge clk); #5;
         if (pred_req) begin
            if (q_exp.size() == 0) begin
               chk(0, "R3 unexpected prediction", 1, 0);
            end else begin
               e = q_exp.pop_front();
               t = q_tag.pop_front();
               chk(pred_from_hist == e[1], {t, " source"}, pred_from_hist, e[1]);
               chk(pred_taken == e[0], {t, " direction"}, pred_taken, e[0]);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit [6:0] pat;
      for (int i = 0; i < 128; i++) m_ctr[i] = 2'b01;
      for (int e = 0; e < NE; e++) begin m_valid[e] = 0; m_len[e] = 0; m_hist[e] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      // R1: reset state
      chk(pkt_hit == 1'b0, "R1 pkt_hit", pkt_hit, 0);
      chk(pred_from_hist == 1'b0, "R1 source", pred_from_hist, 0);
      pred_pc = 32'h104;
      #1;
      chk(pred_taken == 1'b0, "R1 weak not-taken", pred_taken, 0);

      // first packet of key A: miss, record 7 outcomes (R1, R5, R6)
      pat = 7'b1001101;
      start(32'hA000_0001, 0, 0);
      for (int i = 0; i < 7; i++) br(32'h100 + 4 * i, pat[i], "R6");
      // second packet of A: replay (R3), flip bit 2 (R7), run past length (R4)
      start(32'hA000_0001, 0, 0);
      for (int i = 0; i < 9; i++)
         br(32'h100 + 4 * i, (i == 2) ? ~pat[i] : (i < 7 ? pat[i] : 1'b1), i >= 7 ? "R4" : "R3");
      // third packet: split predict / resolve, bit 2 must be updated (R7)
      start(32'hA000_0001, 0, 0);
      for (int i = 0; i < 7; i++) begin
         drive(0, 0, 1, 32'h100 + 4 * i, 0, 0, 0, i == 2 ? "R7" : "");
         drive(0, 0, 0, 0, 1, 32'h100 + 4 * i, pat[i], "");
      end
      // pkt_start with predict and resolve in the same cycle (R9)
      start(32'hA000_0001, 1, 1);
      for (int i = 0; i < 4; i++) br(32'h100 + 4 * i, ~pat[i], "");
      idle();
      // long miss packet: record saturates at HM (R6)
      start(32'hB000_0002, 0, 0);
      for (int i = 0; i < HM + 2; i++) br(32'h400 + 4 * (i % 11), (i % 3) == 0, "R6");
      start(32'hB000_0002, 0, 0);
      for (int i = 0; i < HM + 2; i++)
         br(32'h400 + 4 * (i % 11), (i % 5) != 0, i >= HM ? "R4" : "");
      // gshare training and saturation (R8)
      start(32'hE000_0005, 0, 0);
      for (int i = 0; i < 8; i++) br(32'h200, 1'b1, "R8");
      for (int i = 0; i < 5; i++) br(32'h200, 1'b0, "R8");
      // fill remaining entries, then wrap round-robin (R5)
      for (int k = 0; k < 13; k++) begin
         start(32'hC000_0000 + k, 0, 0);
         br(32'h500 + 4 * k, k[0], "");
         br(32'h504 + 4 * k, ~k[0], "");
      end
      start(32'hD000_0004, 0, 0);   // takes entry 0, evicts A
      br(32'h600, 1'b1, "");
      start(32'hA000_0001, 0, 0);   // A misses, takes entry 1, evicts B
      br(32'h100, 1'b0, "R5");
      start(32'hB000_0002, 0, 0);   // B misses
      start(32'hC000_0000, 0, 0);   // still resident, hits
      br(32'h500, 1'b0, "R3");
      idle();
      repeat (3) @(negedge clk);
      chk(q_exp.size() == 0, "R3 scoreboard drained", q_exp.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule